// File: doc/BRIEF.md
# Radix-8 Booth Partial-Product Slice

This block is one column slice of a radix-8 Booth multiplier array. It takes thirteen multiplier bits that form four overlapping Booth groups, an 8-bit window of the multiplicand Y together with the two Y bits just below that window, and the matching 8-bit window of a precomputed 3Y. For each group it picks one of the multiples 0, Y, 2Y, 3Y or 4Y, inverting the row when the digit is negative. It then compresses the four rows into one sum row and one carry row with two levels of 3:2 counters.

Every row of a negative digit owes a one at its least significant position, which turns the ones' complement into a two's complement. These owed ones are not added inside the slice. They leave on a 4-bit flag output, and the next compression stage injects them. Sign-extension columns above the window are handled by an edge variant of the slice, so all arithmetic in this slice is modulo 2^8. The result is captured into an output register behind a valid/ready handshake that holds one transaction.

Top module: `booth8_pp_slice`

## Requirements
- R1: Group k (k = 0..3) is mplr_bits[3k+3:3k], with bit 0 of each group shared with the group below. Its digit is -4*g[3] + 2*g[2] + g[1] + g[0], in the range -4..+4.
- R2: The row magnitude for digit size 1 is y_win. Size 2 is {y_win[6:0], y_low[1]}. Size 3 is y3_win, used exactly as supplied. Size 4 is {y_win[5:0], y_low[1:0]}. Size 0 is zero.
- R3: A negative digit yields the bitwise inverse of its magnitude row and sets row_neg[k] = 1. The groups 4'b0000 and 4'b1111 give a zero row with row_neg[k] = 0.
- R4: Modulo 256, sum_row + 2*carry_row + (number of ones in row_neg) equals the sum of the four signed multiples. carry_row bit j carries weight 2^(j+1).
- R5: A transaction accepted at a rising edge is visible on the outputs with out_valid = 1 right after that edge. With out_ready = 1 and no new input, out_valid falls at the next edge.
- R6: in_ready = 1 whenever out_valid = 0 or out_ready = 1. While out_valid = 1 and out_ready = 0, no input is taken and all outputs hold their values.
- R7: After reset, out_valid = 0, sum_row, carry_row and row_neg are zero, and in_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operands present |
| in_ready | output | 1 | Slice can take an input this cycle |
| mplr_bits | input | 13 | Multiplier bits forming four overlapping Booth groups |
| y_win | input | 8 | Multiplicand window |
| y_low | input | 2 | Two multiplicand bits just below the window |
| y3_win | input | 8 | Precomputed 3Y window |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Consumer takes the result |
| sum_row | output | 8 | Compressed sum row, weights 2^0..2^7 |
| carry_row | output | 7 | Compressed carry row, weights 2^1..2^7 |
| row_neg | output | 4 | Per-row owed LSB one (negative digit) |

## Verification
A wrong digit decode, a wrong neighbour-bit routing for 2Y or 4Y, or a faulty counter bit changes the modular total seen on the ports. It shows in the very next registered result for that input pattern. The bench sweeps all 8192 multiplier patterns against several multiplicand windows, and sweeps every multiplicand window with every pair of low bits, so each such fault reaches the ports within a few hundred transactions. A wrong negative flag appears directly on row_neg in the cycle after acceptance. A handshake fault appears as a changed output, or as a lost or doubled out_valid, during the back-pressure sequence.

// File: rtl/booth8_pkg.sv
package booth8_pkg;
    localparam int ROWS  = 4;
    localparam int NMULT = 5;
    localparam int M_ZERO  = 0;
    localparam int M_ONE   = 1;
    localparam int M_TWO   = 2;
    localparam int M_THREE = 3;
    localparam int M_FOUR  = 4;

    typedef struct packed {
        logic             neg;
        logic [NMULT-1:0] sel;   // one-hot, index = magnitude
    } digit_t;
endpackage

// File: rtl/booth8_recode.sv
module booth8_recode
    import booth8_pkg::*;
(
    input  logic [3:0] grp,
    output digit_t     dig
);
    logic [2:0] pos_c;
    logic [2:0] mag_c;

    always_comb begin
        pos_c   = {1'b0, grp[2], 1'b0} + {2'b00, grp[1]} + {2'b00, grp[0]};
        dig.neg = grp[3] && (pos_c != 3'd4);
        mag_c   = grp[3] ? (3'd4 - pos_c) : pos_c;
        dig.sel = NMULT'(1) << mag_c;
    end
endmodule

// File: rtl/booth8_row_sel.sv
module booth8_row_sel
    import booth8_pkg::*;
#(
    parameter int W = 8
) (
    input  digit_t       dig,
    input  logic [W-1:0] y_win,
    input  logic [1:0]   y_low,
    input  logic [W-1:0] y3_win,
    output logic [W-1:0] row,
    output logic         neg
);
    logic [W-1:0] twice_c;
    logic [W-1:0] quad_c;
    logic [W-1:0] mag_c;

    always_comb begin
        twice_c = {y_win[W-2:0], y_low[1]};
        quad_c  = {y_win[W-3:0], y_low};
        mag_c   = ({W{dig.sel[M_ONE]}}   & y_win)
                | ({W{dig.sel[M_TWO]}}   & twice_c)
                | ({W{dig.sel[M_THREE]}} & y3_win)
                | ({W{dig.sel[M_FOUR]}}  & quad_c);
        row     = dig.neg ? ~mag_c : mag_c;
        neg     = dig.neg;
    end
endmodule

// File: rtl/booth8_csa.sv
module booth8_csa #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-2:0] cy   // bit j has weight 2^(j+1)
);
    always_comb s = a ^ b ^ c;

    for (genvar j = 0; j < W - 1; j++) begin : g_maj
        always_comb cy[j] = (a[j] & b[j]) | (a[j] & c[j]) | (b[j] & c[j]);
    end
endmodule

// File: rtl/booth8_pp_slice.sv
module booth8_pp_slice
    import booth8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [3*ROWS:0]     mplr_bits,
    input  logic [W-1:0]        y_win,
    input  logic [1:0]          y_low,
    input  logic [W-1:0]        y3_win,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [W-1:0]        sum_row,
    output logic [W-2:0]        carry_row,
    output logic [ROWS-1:0]     row_neg
);
    typedef struct packed {
        logic            vld;
        logic [W-1:0]    sum;
        logic [W-2:0]    cy;
        logic [ROWS-1:0] neg;
    } slot_t;

    digit_t          dig   [ROWS];
    logic [W-1:0]    rows  [ROWS];
    logic [ROWS-1:0] neg_c;
    logic [W-1:0]    s1_c, s2_c;
    logic [W-2:0]    c1_c, c2_c;
    slot_t           st_d, st_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        booth8_recode u_rec (
            .grp (mplr_bits[3*r+3:3*r]),
            .dig (dig[r])
        );
        booth8_row_sel #(.W(W)) u_sel (
            .dig    (dig[r]),
            .y_win  (y_win),
            .y_low  (y_low),
            .y3_win (y3_win),
            .row    (rows[r]),
            .neg    (neg_c[r])
        );

        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(dig[r].sel) == 1);                               // R1
        AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            dig[r].neg |-> !dig[r].sel[M_ZERO]);                        // R3
    end

    booth8_csa #(.W(W)) u_csa_a (
        .a  (rows[0]),
        .b  (rows[1]),
        .c  (rows[2]),
        .s  (s1_c),
        .cy (c1_c)
    );

    booth8_csa #(.W(W)) u_csa_b (
        .a  (s1_c),
        .b  ({c1_c, 1'b0}),
        .c  (rows[3]),
        .s  (s2_c),
        .cy (c2_c)
    );

    AST_SUM_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        W'(s2_c + {c2_c, 1'b0}) == W'(rows[0] + rows[1] + rows[2] + rows[3])); // R4

    always_comb in_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready) st_d.vld = 1'b0;
        if (in_valid && in_ready) begin
            st_d.vld = 1'b1;
            st_d.sum = s2_c;
            st_d.cy  = c2_c;
            st_d.neg = neg_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        out_valid = st_q.vld;
        sum_row   = st_q.sum;
        carry_row = st_q.cy;
        row_neg   = st_q.neg;
    end

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);                            // R5
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);            // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(sum_row)
            && $stable(carry_row) && $stable(row_neg));                 // R6
endmodule

// File: tb/test_booth8_pp_slice.sv
module test_booth8_pp_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [12:0] mplr_bits = '0;
    logic [7:0]  y_win = '0;
    logic [1:0]  y_low = '0;
    logic [7:0]  y3_win = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  sum_row;
    logic [6:0]  carry_row;
    logic [3:0]  row_neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    booth8_pp_slice i_booth8_pp_slice (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mplr_bits(mplr_bits), .y_win(y_win), .y_low(y_low), .y3_win(y3_win),
        .out_valid(out_valid), .out_ready(out_ready), .sum_row(sum_row),
        .carry_row(carry_row), .row_neg(row_neg)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected modular total (R1..R4) and expected negative flags.
    function automatic int exp_total(input int m, input int y, input int yl, input int y3);
        int tot = 0;
        for (int k = 0; k < 4; k++) begin
            int g = (m >> (3 * k)) & 15;
            int d = -4 * ((g >> 3) & 1) + 2 * ((g >> 2) & 1) + ((g >> 1) & 1) + (g & 1);
            int a = (d < 0) ? -d : d;
            int mv = 0;
            case (a)
                1: mv = y;
                2: mv = ((y << 1) | (yl >> 1)) & 255;
                3: mv = y3;
                4: mv = ((y << 2) | yl) & 255;
                default: mv = 0;
            endcase
            tot += (d < 0) ? (256 - mv) : mv;
        end
        return tot & 255;
    endfunction

    function automatic int exp_neg(input int m);
        int n = 0;
        for (int k = 0; k < 4; k++) begin
            int g = (m >> (3 * k)) & 15;
            if (g[3] && g != 15) n |= (1 << k);
        end
        return n;
    endfunction

    function automatic int obs_total();
        return (int'(sum_row) + 2 * int'(carry_row) + $countones(row_neg)) & 255;
    endfunction

    task automatic run_op(input int m, input int y, input int yl, input int y3, input string req);
        @(negedge clk);
        mplr_bits = 13'(m); y_win = 8'(y); y_low = 2'(yl); y3_win = 8'(y3);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R5 valid", int'(out_valid), 1);
        check(obs_total() == exp_total(m, y, yl, y3), req, obs_total(), exp_total(m, y, yl, y3));
        check(int'(row_neg) == exp_neg(m), "R3 row_neg", int'(row_neg), exp_neg(m));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ys[4] = '{8'h00, 8'hFF, 8'hA7, 8'h3C};
        int y3s[4] = '{8'h00, 8'hFD, 8'h5B, 8'hB4};
        repeat (3) @(negedge clk);
        // R7 reset state
        check(out_valid === 1'b0, "R7 out_valid", int'(out_valid), 0);
        check(sum_row === 8'h00 && carry_row === 7'h00, "R7 rows", int'(sum_row), 0);
        check(row_neg === 4'h0, "R7 row_neg", int'(row_neg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R7 in_ready", int'(in_ready), 1);

        // R1 R2 R3 R4: every multiplier pattern against several windows
        for (int k = 0; k < 4; k++)
            for (int m = 0; m < 8192; m++)
                run_op(m, ys[k], m & 3, y3s[k], "R4 total (mplr sweep)");

        // R2: every Y window with every low-bit pair; 3Y deliberately not 3*Y
        for (int y = 0; y < 256; y++)
            for (int yl = 0; yl < 4; yl++)
                run_op((y * 29 + yl * 1031) & 13'h1FFF, y, yl, (y * 7 + 13) & 255, "R2 total (Y sweep)");

        // R3: all-zero and all-ones groups give zero with no flags
        run_op(13'h0000, 8'hC3, 2'b11, 8'h99, "R3 zero digits");
        run_op(13'h1FFF, 8'hC3, 2'b11, 8'h99, "R3 negative-zero digits");

        // R6: back-pressure holds output and refuses new input
        @(negedge clk);
        out_ready = 1'b0;
        mplr_bits = 13'h0123; y_win = 8'h5E; y_low = 2'b10; y3_win = 8'h1A;
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b1, "R6 held valid", int'(out_valid), 1);
        check(in_ready === 1'b0, "R6 in_ready low", int'(in_ready), 0);
        mplr_bits = 13'h1A5C; y_win = 8'h91; y_low = 2'b01; y3_win = 8'hB3;
        repeat (3) @(negedge clk);
        check(obs_total() == exp_total(13'h0123, 8'h5E, 2, 8'h1A), "R6 held total",
              obs_total(), exp_total(13'h0123, 8'h5E, 2, 8'h1A));
        check(int'(row_neg) == exp_neg(13'h0123), "R6 held row_neg", int'(row_neg), exp_neg(13'h0123));
        out_ready = 1'b1;
        #0;
        check(in_ready === 1'b1, "R6 in_ready with out_ready", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        check(obs_total() == exp_total(13'h1A5C, 8'h91, 1, 8'hB3), "R6 released total",
              obs_total(), exp_total(13'h1A5C, 8'h91, 1, 8'hB3));
        @(negedge clk);
        check(out_valid === 1'b0, "R5 valid drops", int'(out_valid), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule